// File: doc/BRIEF.md
# Packet-Resend FIFO with Read Mark

A single-clock first-in first-out buffer, nine bits wide by default, built around an internal register array. Words leave in the order they arrived. Besides the write and read pointers it keeps a third pointer, the mark. A mark strobe records where reading currently stands. A later retransmit strobe moves the read position back to that record, so a packet that the far end rejected can be read out again. This can be done as many times as needed.

Reads are registered. The word appears one clock after an accepted read request, together with a one-cycle valid pulse. Valid stays low in every cycle without a read, which stands in for undriven output pins. Empty and full come straight from the pointer registers, so they are correct in the first cycle after any pointer update, including a retransmit. Once a mark is armed, the block refuses writes that would overwrite the marked word. A synchronous master clear and an asynchronous active-low reset both return the buffer to its empty state.

Top module: `mark_fifo`

## Requirements
- R1: After rst_n low or a cycle with clr high, the buffer is empty: empty=1, full=0 and rd_valid=0. All three pointers are zero and no mark is armed.
- R2: Data leaves in write order. An accepted read presents its word on rd_data, with rd_valid=1, exactly one clock later. rd_valid is 0 in every cycle that does not follow an accepted read.
- R3: full=1 exactly when DEPTH words are stored. A write while full is ignored, and the stored contents and order stay unchanged.
- R4: A read while empty is ignored: rd_valid stays 0 and no pointer moves.
- R5: A mark strobe without a retransmit strobe records the current read position, meaning the word the next read would return. A mark and a read in the same cycle record the position before that read.
- R6: A retransmit strobe, with a mark armed, moves the read position to the recorded mark. Occupancy becomes write position minus mark, and the following reads return the words again, starting from the marked one.
- R7: Retransmit can be repeated any number of times from the same mark, and each repeat resends the same sequence.
- R8: When mark and retransmit are both asserted in one cycle, the retransmit is performed and the recorded mark keeps its old value.
- R9: A read request in the same cycle as a performed retransmit is not accepted, and no rd_valid pulse follows.
- R10: A retransmit strobe with no mark armed since the last clear has no effect on the read position or the flags.
- R11: While a mark is armed, a write is refused once the write position is DEPTH words ahead of the mark. This holds even when full=0, because such a write would overwrite the marked word.
- R12: empty and full are correct in the first cycle after a retransmit, counted against the new read position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous master clear, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| mark | input | 1 | Record the current read position |
| retx | input | 1 | Return the read position to the recorded mark |
| rd_data | output | DATA_W | Word returned by the previous accepted read |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |

## Verification
Retransmit can meet either a mark request or a read request in the same clock, and the bench drives both pairs within its vector table. The mark-plus-retransmit case is judged by what is read next. A later retransmit with read must rewind to the old mark, and the words that follow must be the old packet rather than an empty buffer. The retransmit-plus-read case is judged by the missing valid pulse in the next cycle, and then by the rewound word appearing on the following read.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;

  // One cycle worth of requests at the block edge.
  typedef struct packed {
    logic wr;
    logic rd;
    logic mk;
    logic rt;
  } mf_req_t;

endpackage

// File: rtl/mfifo_ctrl.sv
module mfifo_ctrl
  import mfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  mf_req_t       req,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] mptr,
  output logic          armed,
  output logic          wr_go,
  output logic          rd_go,
  output logic          empty,
  output logic          full
);

  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [PW-1:0] wptr_q, rptr_q, mptr_q;
  logic [PW-1:0] wptr_d, rptr_d, mptr_d;
  logic          armed_q, armed_d;
  logic [PW-1:0] occ, span;
  logic          guard, rt_go, mk_go;

  // Flags and acceptance, all from registered pointers
  always_comb begin
    occ   = wptr_q - rptr_q;
    span  = wptr_q - mptr_q;
    empty = (occ == '0);
    full  = (occ == CAP);
    guard = armed_q && (span == CAP);
    wr_go = req.wr && !full && !guard && !clr;
    rt_go = req.rt && armed_q && !clr;
    rd_go = req.rd && !empty && !rt_go && !clr;
    mk_go = req.mk && !req.rt && !clr;
  end

  // Next-state
  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    mptr_d  = mptr_q;
    armed_d = armed_q;
    if (clr) begin
      wptr_d  = '0;
      rptr_d  = '0;
      mptr_d  = '0;
      armed_d = 1'b0;
    end else begin
      if (wr_go) wptr_d = wptr_q + 1'b1;
      if (rt_go)      rptr_d = mptr_q;
      else if (rd_go) rptr_d = rptr_q + 1'b1;
      if (mk_go) begin
        mptr_d  = rptr_q;
        armed_d = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      mptr_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      mptr_q  <= mptr_d;
      armed_q <= armed_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign mptr  = mptr_q;
  assign armed = armed_q;

endmodule

// File: rtl/mfifo_store.sv
module mfifo_store #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) q <= wdata;
    end
    assign rows[g] = q;
  end

  assign rdata = rows[raddr];

endmodule

// File: rtl/mfifo_outreg.sv
module mfifo_outreg #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;

  always_comb begin
    vld_d  = load;
    data_d = load ? din : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign dout  = data_q;
  assign valid = vld_q;

endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
  import mfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              mark,
  input  logic              retx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              full
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  mf_req_t           req;
  logic [PW-1:0]     wptr, rptr, mptr;
  logic              armed, wr_go, rd_go;
  logic [DATA_W-1:0] mem_q;

  assign req = '{wr: wr_en, rd: rd_en, mk: mark, rt: retx};

  mfifo_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .req   (req),
    .wptr  (wptr),
    .rptr  (rptr),
    .mptr  (mptr),
    .armed (armed),
    .wr_go (wr_go),
    .rd_go (rd_go),
    .empty (empty),
    .full  (full)
  );

  mfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rptr[AW-1:0]),
    .rdata (mem_q)
  );

  mfifo_outreg #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_go),
    .din   (mem_q),
    .dout  (rd_data),
    .valid (rd_valid)
  );

endmodule

// File: rtl/mfifo_chk.sv
module mfifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          wr_en,
  input logic          rd_en,
  input logic          mark,
  input logic          retx,
  input logic          rd_valid,
  input logic          empty,
  input logic          full,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] mptr,
  input logic          armed
);

  logic [PW-1:0] occ_c, span_c;
  assign occ_c  = wptr - rptr;
  assign span_c = wptr - mptr;

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !full && !rd_valid && wptr == '0 && rptr == '0 && !armed));

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !retx && !clr) |=> rd_valid);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_c <= PW'(DEPTH));

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !clr) |=> $stable(wptr));

  a_r4_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !rd_valid);

  a_r5_mark_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !retx && !clr) |=> (mptr == $past(rptr)));

  a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (retx && armed && !clr) |=> (rptr == $past(mptr)));

  a_r8_mark_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && retx && !clr) |=> $stable(mptr));

  a_r9_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (retx && armed && rd_en && !clr) |=> !rd_valid);

  a_r10_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (retx && !armed && !rd_en && !clr) |=> $stable(rptr));

  a_r11_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && span_c == PW'(DEPTH) && !clr) |=> $stable(wptr));

endmodule

bind mark_fifo mfifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .mark     (mark),
  .retx     (retx),
  .rd_valid (rd_valid),
  .empty    (empty),
  .full     (full),
  .wptr     (wptr),
  .rptr     (rptr),
  .mptr     (mptr),
  .armed    (armed)
);

// File: tb/test_mark_fifo.sv
`timescale 1ns/1ps
module test_mark_fifo;

  localparam int DW = 9;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst_n, clr, wr_en, rd_en, mark, retx;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_valid, empty, full;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mark_fifo #(.DATA_W(DW), .DEPTH(DP)) i_mark_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .mark(mark), .retx(retx), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty), .full(full)
  );

  // fields: wr rd mk rt | din[9] | exp_valid | exp_data[9] | exp_empty | exp_full
  localparam logic [24:0] VEC [16] = '{
    {4'b1000, 9'h101, 1'b0, 9'h000, 1'b0, 1'b0},  // R2 write
    {4'b1000, 9'h0A2, 1'b0, 9'h000, 1'b0, 1'b0},
    {4'b1000, 9'h1F3, 1'b0, 9'h000, 1'b0, 1'b0},
    {4'b0100, 9'h000, 1'b1, 9'h101, 1'b0, 1'b0},  // R2 order
    {4'b0010, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0},  // R5 mark at word 0A2
    {4'b0100, 9'h000, 1'b1, 9'h0A2, 1'b0, 1'b0},
    {4'b0100, 9'h000, 1'b1, 9'h1F3, 1'b1, 1'b0},
    {4'b0100, 9'h000, 1'b0, 9'h000, 1'b1, 1'b0},  // R4 read when empty
    {4'b0001, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0},  // R6 R12 retransmit
    {4'b0100, 9'h000, 1'b1, 9'h0A2, 1'b0, 1'b0},  // R6 resend
    {4'b1100, 9'h055, 1'b1, 9'h1F3, 1'b0, 1'b0},
    {4'b0100, 9'h000, 1'b1, 9'h055, 1'b1, 1'b0},
    {4'b0011, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0},  // R8 R7 both strobes
    {4'b0100, 9'h000, 1'b1, 9'h0A2, 1'b0, 1'b0},  // R7 second resend
    {4'b0101, 9'h000, 1'b0, 9'h000, 1'b0, 1'b0},  // R9 read dropped
    {4'b0100, 9'h000, 1'b1, 9'h0A2, 1'b0, 1'b0}   // R8 mark kept old value
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs across one rising edge.
  task automatic cyc(input logic w, input logic r, input logic m, input logic t,
                     input logic [DW-1:0] d, input logic c = 1'b0);
    wr_en = w; rd_en = r; mark = m; retx = t; wr_data = d; clr = c;
    @(negedge clk);
    wr_en = 0; rd_en = 0; mark = 0; retx = 0; clr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; clr = 0; wr_en = 0; rd_en = 0; mark = 0; retx = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 valid", 32'(rd_valid), 0);

    // vector walk
    for (int i = 0; i < 16; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cyc(v[24], v[23], v[22], v[21], v[20:12]);
      chk($sformatf("R2/vec%0d valid", i), 32'(rd_valid), 32'(v[11]));
      if (v[11]) chk($sformatf("R2/vec%0d data", i), 32'(rd_data), 32'(v[10:2]));
      chk($sformatf("R12/vec%0d empty", i), 32'(empty), 32'(v[1]));
      chk($sformatf("R3/vec%0d full", i), 32'(full), 32'(v[0]));
    end

    // R1 clear, then R10 retransmit with no mark
    cyc(0, 0, 0, 0, '0, 1'b1);
    chk("R1 clr empty", 32'(empty), 1);
    chk("R1 clr valid", 32'(rd_valid), 0);
    cyc(1, 0, 0, 0, 9'h011);
    cyc(1, 0, 0, 0, 9'h022);
    cyc(0, 1, 0, 0, '0);
    chk("R2 data", 32'(rd_data), 32'h011);
    cyc(0, 0, 0, 1, '0);
    chk("R10 empty after unarmed retx", 32'(empty), 0);
    cyc(0, 1, 0, 0, '0);
    chk("R10 next word", 32'(rd_data), 32'h022);
    chk("R10 empty", 32'(empty), 1);

    // R3 fill to capacity and overflow attempt
    cyc(0, 0, 0, 0, '0, 1'b1);
    for (int i = 0; i < DP; i++) cyc(1, 0, 0, 0, DW'(i * 3 + 1));
    chk("R3 full", 32'(full), 1);
    cyc(1, 0, 0, 0, 9'h1AA);
    chk("R3 still full", 32'(full), 1);
    for (int i = 0; i < DP; i++) begin
      cyc(0, 1, 0, 0, '0);
      chk("R3 order", 32'(rd_data), 32'(DW'(i * 3 + 1)));
    end
    chk("R3 overflow dropped", 32'(empty), 1);
    cyc(0, 1, 0, 0, '0);
    chk("R4 no valid", 32'(rd_valid), 0);

    // R11 armed mark guards its word
    cyc(0, 0, 0, 0, '0, 1'b1);
    cyc(0, 0, 1, 0, '0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, DW'(9'h100 + i));
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, 0, 0, '0);
      chk("R5 mark from start", 32'(rd_data), 32'(9'h100 + i));
    end
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, DW'(9'h040 + i));
    chk("R11 not full", 32'(full), 0);
    cyc(1, 0, 0, 0, 9'h1EE);
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 0, 0, '0);
      chk("R11 data", 32'(rd_data), 32'(9'h040 + i));
    end
    chk("R11 guarded write dropped", 32'(empty), 1);
    cyc(0, 0, 0, 1, '0);
    chk("R12 full after retx", 32'(full), 1);
    cyc(0, 1, 0, 0, '0);
    chk("R6 marked word", 32'(rd_data), 32'h100);

    // R1 asynchronous reset mid-stream
    #1 rst_n = 0;
    #0.5;
    chk("R1 async empty", 32'(empty), 1);
    chk("R1 async valid", 32'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule